// File: doc/BRIEF.md
# Scoreboard In-Order Issue Controller

This block is the fetch, decode and issue control of an in-order pipeline that takes in one instruction per cycle. Each instruction is either an ADD or a MUL. It names one destination register and two source registers. The block tracks whether every register holds a settled result. It keeps the oldest instruction in decode until three things are true: its registers are usable, a unit of the right kind can take it, and every older instruction has left. It then issues the instruction to an adder with a four-cycle execute latency or to a multiplier with a six-cycle execute latency. After the last execute cycle comes one store (writeback) cycle.

Two parameters select the timing variant. `FORWARD` lets a consumer issue one cycle earlier than it could without forwarding. `PIPELINED` lets a unit accept a new operation every cycle; when it is off, a unit takes a new operation only after its current one has used all of its execute cycles. The block carries no data values. Its outputs are per-cycle events: issue, stall, writeback, scoreboard state and unit occupancy. A surrounding model or bench can use them to count the total cycles of an instruction sequence.

Top module: `sb_issue_ctrl`

## Requirements
- R1: In the first cycle after synchronous reset, all of the following hold: every scoreboard bit reads valid, decode is empty, `in_ready` is high, nothing issues or stalls, no writeback is flagged, and both occupancy counts are zero.
- R2: The fetch register takes in an instruction when it is empty or when its content moves to decode in the same cycle. An instruction taken in cycle a moves to decode no earlier than cycle a+2. At most one instruction issues per cycle, strictly in program order, and `issue_dst` carries the destination of the issuing instruction.
- R3: An instruction in decode issues only when all of the following hold: both of its sources are usable, its destination is usable, and its unit can accept. While it waits, `stall` is high, it stays in decode, and a fetched instruction behind it stays in fetch.
- R4: When an instruction issues in cycle t with latency L, its destination's scoreboard bit is low from cycle t+1 through t+L+1. `wb_mask` flags that register in cycle t+L+1, and the bit reads valid again from t+L+2. A destination counts as usable only when its bit is valid or its pending write is in its store cycle.
- R5: Without forwarding, a consumer of a register may issue no earlier than the producer's store cycle, so it executes in the following cycle.
- R6: With forwarding, a consumer of a source register may issue one cycle before the producer's store cycle.
- R7: With non-pipelined units, two issues of the same type are at least L cycles apart, where L is that type's latency.
- R8: With pipelined units, independent operations of the same type may issue on consecutive cycles.
- R9: `add_occ` and `mul_occ` equal the number of operations in the execute cycles of the adder and of the multiplier. An operation issued in cycle t is counted from cycle t+1 through t+L.
- R10: `in_op` is encoded 0 for ADD (latency `ADD_LAT`, default 4) and 1 for MUL (latency `MUL_LAT`, default 6). `issue_op` uses the same encoding.
- R11: The test sequence runs MUL r1; ADD r2←r1; ADD r3; MUL r0; ADD r3←r0,r1; MUL r1←r2. Counting the first fetch cycle as 1, its last store cycle is 29 (units not pipelined, no forwarding), 27 (not pipelined, forwarding), 26 (pipelined, no forwarding) or 24 (pipelined, forwarding).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is offered to fetch |
| in_op | input | 1 | Operation: 0 ADD, 1 MUL |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| in_ready | output | 1 | Fetch takes the offered instruction this cycle |
| dec_valid | output | 1 | Decode holds an instruction |
| stall | output | 1 | Decode holds an instruction that cannot issue |
| issue_valid | output | 1 | The decode instruction issues this cycle |
| issue_op | output | 1 | Operation of the issuing instruction |
| issue_dst | output | REG_W | Destination of the issuing instruction |
| add_occ | output | ADD_OCC_W | ADD operations in execute cycles |
| mul_occ | output | MUL_OCC_W | MUL operations in execute cycles |
| wb_mask | output | NREG | Registers in their store cycle |
| sb_valid | output | NREG | Scoreboard valid bit per register |

## Verification
All four settings of the two switches are run on three instruction streams. The first is the six-instruction dependency chain. Its final store cycle takes a different value in each of the four settings, so it tells forwarding apart from writeback-only visibility and shared units apart from pipelined ones. The second is three independent ADDs: these issue one, or four, cycles apart, which isolates the structural hazard from data hazards. The third is a 40-instruction pseudo-random stream over four registers. It is dense in read-after-write and write-after-write conflicts, and every output is compared on every cycle against timing equations that the bench derives.

// File: rtl/sbi_pkg.sv
package sbi_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_MUL = 1'b1
    } op_e;

    // Highest remaining-cycle count at which a pending source may be read.
    function automatic int unsigned src_window(bit fwd);
        return fwd ? 2 : 1;
    endfunction

    // Cycles from the issue edge through the store cycle.
    function automatic int unsigned span_of(op_e op, int unsigned add_lat, int unsigned mul_lat);
        return ((op == OP_MUL) ? mul_lat : add_lat) + 1;
    endfunction

endpackage

// File: rtl/sbi_stage_pair.sv
module sbi_stage_pair #(
    parameter type item_t = logic
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  item_t in_item,
    output logic  in_ready,
    input  logic  advance,
    output logic  dec_valid,
    output item_t dec_item
);

    logic  fet_v_q, dec_v_q;
    item_t fet_q, dec_q;
    logic  dec_free;

    assign dec_free  = !dec_v_q || advance;
    assign in_ready  = !fet_v_q || dec_free;
    assign dec_valid = dec_v_q;
    assign dec_item  = dec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fet_v_q <= 1'b0;
            dec_v_q <= 1'b0;
            fet_q   <= '0;
            dec_q   <= '0;
        end else begin
            if (dec_free) begin
                dec_v_q <= fet_v_q;
                dec_q   <= fet_q;
            end
            if (in_ready) begin
                fet_v_q <= in_valid;
                fet_q   <= in_item;
            end
        end
    end

endmodule

// File: rtl/sbi_scoreboard.sv
module sbi_scoreboard #(
    parameter int NREG    = 8,
    parameter int REG_W   = 3,
    parameter int CNT_W   = 3,
    parameter bit FORWARD = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_dst,
    input  logic [CNT_W-1:0] set_span,
    output logic [NREG-1:0]  src_ok,
    output logic [NREG-1:0]  dst_ok,
    output logic [NREG-1:0]  valid,
    output logic [NREG-1:0]  wb
);
    import sbi_pkg::*;

    localparam logic [CNT_W-1:0] SRC_WIN = CNT_W'(src_window(FORWARD));
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [CNT_W-1:0] left_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                left_q <= '0;
            end else if (set_en && (set_dst == REG_W'(r))) begin
                left_q <= set_span;
            end else if (left_q != '0) begin
                left_q <= left_q - ONE;
            end
        end

        assign valid[r]  = (left_q == '0);
        assign wb[r]     = (left_q == ONE);
        assign dst_ok[r] = (left_q <= ONE);
        assign src_ok[r] = (left_q <= SRC_WIN);
    end

endmodule

// File: rtl/sbi_unit.sv
module sbi_unit #(
    parameter int LAT       = 4,
    parameter bit PIPELINED = 1'b0,
    parameter int OCC_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             free,
    output logic [OCC_W-1:0] occ
);

    logic [LAT-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[LAT-2:0], start};
        end
    end

    if (PIPELINED) begin : g_pipe
        assign free = 1'b1;
    end else begin : g_shared
        // The unit is free next cycle when only the last execute slot is taken.
        assign free = ~|stage_q[LAT-2:0];
    end

    assign occ = OCC_W'($countones(stage_q));

endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
    import sbi_pkg::*;
#(
    parameter int NREG      = 8,
    parameter int ADD_LAT   = 4,
    parameter int MUL_LAT   = 6,
    parameter bit PIPELINED = 1'b0,
    parameter bit FORWARD   = 1'b0,
    localparam int REG_W     = $clog2(NREG),
    localparam int ADD_OCC_W = $clog2(ADD_LAT + 1),
    localparam int MUL_OCC_W = $clog2(MUL_LAT + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_op,
    input  logic [REG_W-1:0]     in_dst,
    input  logic [REG_W-1:0]     in_src1,
    input  logic [REG_W-1:0]     in_src2,
    output logic                 in_ready,
    output logic                 dec_valid,
    output logic                 stall,
    output logic                 issue_valid,
    output logic                 issue_op,
    output logic [REG_W-1:0]     issue_dst,
    output logic [ADD_OCC_W-1:0] add_occ,
    output logic [MUL_OCC_W-1:0] mul_occ,
    output logic [NREG-1:0]      wb_mask,
    output logic [NREG-1:0]      sb_valid
);

    localparam int MAX_LAT = (ADD_LAT > MUL_LAT) ? ADD_LAT : MUL_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 2);

    typedef struct packed {
        op_e              op;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src1;
        logic [REG_W-1:0] src2;
    } instr_t;

    instr_t           fetch_in, dec_q;
    logic             dec_v, go;
    logic [NREG-1:0]  src_ok, dst_ok;
    logic             add_free, mul_free, unit_ok, regs_ok;
    logic [CNT_W-1:0] span;

    assign fetch_in = '{op: op_e'(in_op), dst: in_dst, src1: in_src1, src2: in_src2};

    sbi_stage_pair #(.item_t(instr_t)) u_front (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_item   (fetch_in),
        .in_ready  (in_ready),
        .advance   (go),
        .dec_valid (dec_v),
        .dec_item  (dec_q)
    );

    assign regs_ok = src_ok[dec_q.src1] && src_ok[dec_q.src2] && dst_ok[dec_q.dst];
    assign unit_ok = (dec_q.op == OP_MUL) ? mul_free : add_free;
    assign go      = dec_v && regs_ok && unit_ok;
    assign span    = CNT_W'(span_of(dec_q.op, ADD_LAT, MUL_LAT));

    sbi_scoreboard #(
        .NREG    (NREG),
        .REG_W   (REG_W),
        .CNT_W   (CNT_W),
        .FORWARD (FORWARD)
    ) u_sb (
        .clk      (clk),
        .rst      (rst),
        .set_en   (go),
        .set_dst  (dec_q.dst),
        .set_span (span),
        .src_ok   (src_ok),
        .dst_ok   (dst_ok),
        .valid    (sb_valid),
        .wb       (wb_mask)
    );

    sbi_unit #(.LAT(ADD_LAT), .PIPELINED(PIPELINED), .OCC_W(ADD_OCC_W)) u_add (
        .clk   (clk),
        .rst   (rst),
        .start (go && (dec_q.op == OP_ADD)),
        .free  (add_free),
        .occ   (add_occ)
    );

    sbi_unit #(.LAT(MUL_LAT), .PIPELINED(PIPELINED), .OCC_W(MUL_OCC_W)) u_mul (
        .clk   (clk),
        .rst   (rst),
        .start (go && (dec_q.op == OP_MUL)),
        .free  (mul_free),
        .occ   (mul_occ)
    );

    assign dec_valid   = dec_v;
    assign stall       = dec_v && !go;
    assign issue_valid = go;
    assign issue_op    = dec_q.op;
    assign issue_dst   = dec_q.dst;

endmodule

// File: rtl/sb_issue_ctrl_chk.sv
module sb_issue_ctrl_chk #(
    parameter int NREG      = 8,
    parameter int ADD_LAT   = 4,
    parameter int MUL_LAT   = 6,
    parameter bit PIPELINED = 1'b0,
    parameter int REG_W     = 3,
    parameter int ADD_OCC_W = 3,
    parameter int MUL_OCC_W = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 dec_valid,
    input logic                 stall,
    input logic                 issue_valid,
    input logic [REG_W-1:0]     issue_dst,
    input logic [ADD_OCC_W-1:0] add_occ,
    input logic [MUL_OCC_W-1:0] mul_occ,
    input logic [NREG-1:0]      wb_mask,
    input logic [NREG-1:0]      sb_valid
);

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> dec_valid);

    // R4
    dst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> !sb_valid[$past(issue_dst)]);

    // R4
    dst_ready_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (sb_valid[issue_dst] || wb_mask[issue_dst]));

    for (genvar r = 0; r < NREG; r++) begin : g_wb
        // R4
        wb_then_valid_chk: assert property (@(posedge clk) disable iff (rst)
            (wb_mask[r] && !(issue_valid && issue_dst == REG_W'(r))) |=> sb_valid[r]);
    end

    // R9
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(add_occ) <= ADD_LAT) && (int'(mul_occ) <= MUL_LAT));

    if (!PIPELINED) begin : g_shared
        // R7
        single_occ_chk: assert property (@(posedge clk) disable iff (rst)
            (add_occ <= ADD_OCC_W'(1)) && (mul_occ <= MUL_OCC_W'(1)));
    end

endmodule

bind sb_issue_ctrl sb_issue_ctrl_chk #(
    .NREG      (NREG),
    .ADD_LAT   (ADD_LAT),
    .MUL_LAT   (MUL_LAT),
    .PIPELINED (PIPELINED),
    .REG_W     (REG_W),
    .ADD_OCC_W (ADD_OCC_W),
    .MUL_OCC_W (MUL_OCC_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dec_valid   (dec_valid),
    .stall       (stall),
    .issue_valid (issue_valid),
    .issue_dst   (issue_dst),
    .add_occ     (add_occ),
    .mul_occ     (mul_occ),
    .wb_mask     (wb_mask),
    .sb_valid    (sb_valid)
);

// File: tb/tb_sb_issue_ctrl.sv
module tb_sb_issue_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 4;
    localparam int ADD_LAT    = 4;
    localparam int MUL_LAT    = 6;
    localparam int MAXN       = 48;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [3:0] done;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    for (genvar k = 0; k < 4; k++) begin : g_cfg
        localparam bit PIPE = ((k / 2) % 2) == 1;
        localparam bit FWD  = (k % 2) == 1;
        localparam int DOC_TOTAL = (k == 0) ? 29 : (k == 1) ? 27 : (k == 2) ? 26 : 24;

        logic       rst, in_valid, in_op;
        logic [1:0] in_dst, in_s1, in_s2;
        logic       in_ready, dec_valid, stall, issue_valid, issue_op;
        logic [1:0] issue_dst;
        logic [2:0] add_occ, mul_occ;
        logic [3:0] wb_mask, sb_valid;
        logic       fin;

        int q_op [MAXN];
        int q_d  [MAXN];
        int q_a  [MAXN];
        int q_b  [MAXN];
        int m_f  [MAXN];
        int m_d  [MAXN];
        int m_i  [MAXN];
        int m_s  [MAXN];
        int o_i  [MAXN];
        int nq, no, last_wb;

        assign done[k] = fin;

        sb_issue_ctrl #(
            .NREG(NREG), .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT),
            .PIPELINED(PIPE), .FORWARD(FWD)
        ) dut (
            .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
            .in_dst(in_dst), .in_src1(in_s1), .in_src2(in_s2),
            .in_ready(in_ready), .dec_valid(dec_valid), .stall(stall),
            .issue_valid(issue_valid), .issue_op(issue_op), .issue_dst(issue_dst),
            .add_occ(add_occ), .mul_occ(mul_occ), .wb_mask(wb_mask), .sb_valid(sb_valid)
        );

        task automatic put(input int i, input int op, input int d, input int a, input int b);
            q_op[i] = op; q_d[i] = d; q_a[i] = a; q_b[i] = b;
        endtask

        // Timing equations taken from the requirements.
        task automatic build_model();
            int s_time [NREG];
            int last_add, last_mul, prev_a, prev_d, prev_i, acc, lat, t;
            for (int r = 0; r < NREG; r++) s_time[r] = 0;
            last_add = -100; last_mul = -100;
            prev_a = -1; prev_d = 1; prev_i = -1;
            for (int i = 0; i < nq; i++) begin
                lat = (q_op[i] == 1) ? MUL_LAT : ADD_LAT;
                acc = imax(prev_a + 1, prev_d - 1);
                m_f[i] = acc + 1;
                m_d[i] = imax(m_f[i] + 1, prev_i + 1);
                t = m_d[i];
                t = imax(t, s_time[q_a[i]] - (FWD ? 1 : 0));
                t = imax(t, s_time[q_b[i]] - (FWD ? 1 : 0));
                t = imax(t, s_time[q_d[i]]);
                if (!PIPE) t = imax(t, ((q_op[i] == 1) ? last_mul + MUL_LAT : last_add + ADD_LAT));
                m_i[i] = t;
                m_s[i] = t + lat + 1;
                s_time[q_d[i]] = m_s[i];
                if (q_op[i] == 1) last_mul = t; else last_add = t;
                prev_a = acc; prev_d = m_d[i]; prev_i = t;
            end
        endtask

        task automatic reset_dut();
            @(negedge clk);
            rst = 1'b1; in_valid = 1'b0;
            repeat (2) @(negedge clk);
            rst = 1'b0;
        endtask

        task automatic run(input string tag_iss);
            int idx, tend, lat, eop, edst, eadd, emul, ewb, esbv;
            bit fbusy, dbusy, eiss, estall;
            idx = 0; no = 0; last_wb = -1; tend = 0;
            for (int i = 0; i < nq; i++) tend = imax(tend, m_s[i] + 2);
            for (int t = 0; t <= tend; t++) begin
                @(negedge clk);
                fbusy = 0; dbusy = 0; eiss = 0; estall = 0; eop = 0; edst = 0;
                eadd = 0; emul = 0; ewb = 0; esbv = 15;
                for (int i = 0; i < nq; i++) begin
                    lat = (q_op[i] == 1) ? MUL_LAT : ADD_LAT;
                    if (m_f[i] <= t && t < m_d[i]) fbusy = 1;
                    if (m_d[i] <= t && t <= m_i[i]) dbusy = 1;
                    if (m_d[i] <= t && t < m_i[i]) estall = 1;
                    if (m_i[i] == t) begin eiss = 1; eop = q_op[i]; edst = q_d[i]; end
                    if (m_s[i] == t) ewb = ewb | (1 << q_d[i]);
                    if (m_i[i] + 1 <= t && t <= m_s[i]) esbv = esbv & ~(1 << q_d[i]);
                    if (m_i[i] + 1 <= t && t <= m_i[i] + lat) begin
                        if (q_op[i] == 1) emul++; else eadd++;
                    end
                end
                if (t == 0) begin
                    // R1 reset state
                    chk("R1", "sb_valid after reset", int'(sb_valid), 15);
                    chk("R1", "idle after reset", int'({dec_valid, stall, issue_valid}), 0);
                    chk("R1", "in_ready after reset", int'(in_ready), 1);
                end
                chk("R2", "in_ready", int'(in_ready), int'(!fbusy || !dbusy || eiss));
                chk("R2", "dec_valid", int'(dec_valid), int'(dbusy));
                chk(tag_iss, "issue_valid", int'(issue_valid), int'(eiss));
                chk("R3", "stall", int'(stall), int'(estall));
                chk("R4", "wb_mask", int'(wb_mask), ewb);
                chk("R4", "sb_valid", int'(sb_valid), esbv);
                chk("R9", "add_occ", int'(add_occ), eadd);
                chk("R9", "mul_occ", int'(mul_occ), emul);
                if (eiss && issue_valid) begin
                    chk("R10", "issue_op", int'(issue_op), eop);
                    chk("R2", "issue_dst", int'(issue_dst), edst);
                end
                if (issue_valid && no < MAXN) begin o_i[no] = t; no++; end
                if (wb_mask != 4'd0) last_wb = t;
                if (idx < nq && in_ready) begin
                    in_valid = 1'b1; in_op = q_op[idx][0];
                    in_dst = q_d[idx][1:0]; in_s1 = q_a[idx][1:0]; in_s2 = q_b[idx][1:0];
                    idx++;
                end else begin
                    in_valid = 1'b0;
                end
            end
        endtask

        initial begin
            int unsigned x;
            fin = 1'b0; rst = 1'b1; in_valid = 1'b0; in_op = 1'b0;
            in_dst = '0; in_s1 = '0; in_s2 = '0;

            // R11 dependency chain; op code 1 is MUL, 0 is ADD
            nq = 6;
            put(0, 1, 1, 0, 0);
            put(1, 0, 2, 1, 0);
            put(2, 0, 3, 0, 0);
            put(3, 1, 0, 0, 0);
            put(4, 0, 3, 0, 1);
            put(5, 1, 1, 2, 2);
            build_model();
            reset_dut();
            run(FWD ? "R6" : "R5");
            // cycle numbering: first fetch cycle is 1 in both
            chk("R11", "last store cycle", last_wb, DOC_TOTAL);
            chk("R2", "issue count chain", no, nq);

            // Three independent ADDs: structural spacing
            nq = 3;
            put(0, 0, 1, 0, 0);
            put(1, 0, 2, 0, 0);
            put(2, 0, 3, 0, 0);
            build_model();
            reset_dut();
            run(PIPE ? "R8" : "R7");
            for (int j = 0; j < 3; j++) begin
                if (PIPE) chk("R8", "pipelined ADD issue cycle", o_i[j], 2 + j);
                else      chk("R7", "shared ADD issue cycle", o_i[j], 2 + j * ADD_LAT);
            end

            // Dense pseudo-random stream over four registers
            nq = 40;
            x = 32'h1234_5678 + k;
            for (int i = 0; i < nq; i++) begin
                x = x * 32'd1664525 + 32'd1013904223;
                put(i, int'(x[20]), int'(x[23:22]), int'(x[26:25]), int'(x[29:28]));
            end
            build_model();
            reset_dut();
            run(FWD ? "R6" : "R5");
            chk("R3", "issue count random", no, nq);

            fin = 1'b1;
        end
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!(&done) && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!(&done)) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual %0d expected %0d", cyc, WATCHDOG - 1);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule